// File: doc/BRIEF.md
# Two-Halfword Long Branch-and-Link Unit

This unit executes a subroutine call whose 22-bit signed offset is too wide for one 16-bit instruction and is therefore carried by two consecutive halfwords. The first halfword (the prefix) holds the upper part of the offset. The unit adds that part, shifted up by twelve, to the program counter and parks the partial sum in the link register. The second halfword (the suffix) holds the lower part. The unit adds that part, shifted by one, to the parked link value to form the branch target. In the same step it overwrites the link register with the return address.

The suffix also picks the instruction-set mode of the target. The target stays in compressed (16-bit) mode when halfword bit 12 is set, or always when the core variant parameter says so. Otherwise the target is a word-aligned address in the wide mode. Each issued halfword also reports its cost in sequential and non-sequential cycles, so that a timing model can add it up. Outputs are registered and appear one clock after the issue strobe. Instruction fetch, pipeline flush and register storage belong to the surrounding core.

Top module: `long_bl_unit`

## Requirements
- R1: A prefix issue (`isSuffix`=0) asserts `lrWrite` with `lrData` = `pcValue` + (sign-extended `halfword[10:0]` shifted left by 12). `branchReq` and `modeKeep` stay 0.
- R2: A suffix issue (`isSuffix`=1) asserts `branchReq`. The raw target is `lrValue` + (`halfword[10:0]` zero-extended and shifted left by 1), taken modulo 2^32.
- R3: A suffix issue asserts `lrWrite` with `lrData` = (`pcValue` − 2) with bit 0 forced to 1.
- R4: On a suffix, `modeKeep` = `halfword[12]` OR parameter `ALWAYS_KEEP`. When `modeKeep` is 1, `branchTarget` is the raw target with bit 0 set.
- R5: When a suffix has `modeKeep` = 0, `branchTarget` is the raw target with bits [1:0] cleared.
- R6: The cost outputs read `seqCost`=1, `nonseqCost`=0 after a prefix and `seqCost`=2, `nonseqCost`=1 after a suffix. Both read 0 after a cycle with no issue.
- R7: All results appear on the clock edge that follows an `issueValid` cycle. After a cycle without issue, `lrWrite`, `branchReq`, `modeKeep` and both costs are 0.
- R8: While `rstN` is low, every output is 0.
- R9: Halfword bits [15:13] and [11] have no effect on any output, and bit 12 has no effect on a prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A halfword is issued this cycle |
| isSuffix | input | 1 | 0 = prefix halfword, 1 = suffix halfword |
| halfword | input | 16 | Instruction halfword |
| pcValue | input | 32 | Program counter value seen by the instruction |
| lrValue | input | 32 | Current link register value |
| lrWrite | output | 1 | Link register write enable |
| lrData | output | 32 | Value to write to the link register |
| branchReq | output | 1 | Branch request |
| branchTarget | output | 32 | Branch target address |
| modeKeep | output | 1 | Target stays in compressed mode |
| seqCost | output | 2 | Sequential cycles consumed |
| nonseqCost | output | 2 | Non-sequential cycles consumed |

## Verification
The bench aims at the sign boundary of the prefix field. Fields 0x3FF and 0x400 must move the link value up by almost 4 MiB and down by exactly 4 MiB; a design that zero-extended the field would jump forward on 0x400. It drives odd link values and raw targets with bit 1 set into wide-mode suffixes. A design that only cleared bit 0, or that kept bit 1, would then hand out a misaligned word target. It also checks that return addresses wrap at a program counter of 0 or 1. It toggles bits 11 to 15 to catch a decoder that reads the wrong mode bit, and runs a second instance with the variant parameter set, which must keep compressed mode even when bit 12 is clear.

// File: rtl/long_bl_pkg.sv
package long_bl_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic prefixEn;   // load partial target into link register
    logic suffixEn;   // form target, branch, write return address
    logic keepMode;   // target stays in compressed mode
  } blStrobe_t;

endpackage

// File: rtl/long_bl_ctrl.sv
module long_bl_ctrl
  import long_bl_pkg::*;
#(
  parameter int HW_W        = 16,
  parameter int MODE_POS    = 12,
  parameter bit ALWAYS_KEEP = 1'b0,
  parameter int COST_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              isSuffix,
  input  logic [HW_W-1:0]   halfword,
  output blStrobe_t         strobe,
  output logic [COST_W-1:0] seqCost,
  output logic [COST_W-1:0] nonseqCost
);

  localparam logic [COST_W-1:0] PRE_SEQ  = COST_W'(1);
  localparam logic [COST_W-1:0] SUF_SEQ  = COST_W'(2);
  localparam logic [COST_W-1:0] SUF_NSEQ = COST_W'(1);

  logic [COST_W-1:0] seqNext;
  logic [COST_W-1:0] nseqNext;

  always_comb begin
    strobe          = '0;
    strobe.prefixEn = issueValid && !isSuffix;
    strobe.suffixEn = issueValid && isSuffix;
    strobe.keepMode = strobe.suffixEn && (halfword[MODE_POS] || ALWAYS_KEEP);
  end

  always_comb begin
    seqNext  = '0;
    nseqNext = '0;
    if (strobe.prefixEn) begin
      seqNext = PRE_SEQ;
    end else if (strobe.suffixEn) begin
      seqNext  = SUF_SEQ;
      nseqNext = SUF_NSEQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqCost    <= '0;
      nonseqCost <= '0;
    end else begin
      seqCost    <= seqNext;
      nonseqCost <= nseqNext;
    end
  end

  // R7
  idle_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (seqCost == '0 && nonseqCost == '0));

endmodule

// File: rtl/long_bl_datapath.sv
module long_bl_datapath
  import long_bl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int HW_W        = 16,
  parameter int OFF_W       = 11,
  parameter int HIGH_SHIFT  = 12,
  parameter bit ALWAYS_KEEP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  blStrobe_t         strobe,
  input  logic [HW_W-1:0]   halfword,
  input  logic [ADDR_W-1:0] pcValue,
  input  logic [ADDR_W-1:0] lrValue,
  output logic              lrWrite,
  output logic [ADDR_W-1:0] lrData,
  output logic              branchReq,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              modeKeep
);

  localparam int HI_EXT = ADDR_W - OFF_W - HIGH_SHIFT;
  localparam int LO_EXT = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] RET_BACK = ADDR_W'(2);

  logic [OFF_W-1:0]  field;
  logic [ADDR_W-1:0] hiOffset;
  logic [ADDR_W-1:0] loOffset;
  logic [ADDR_W-1:0] partialSum;
  logic [ADDR_W-1:0] rawTarget;
  logic [ADDR_W-1:0] finalTarget;
  logic [ADDR_W-1:0] pcBack;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] lrNext;

  assign field    = halfword[OFF_W-1:0];
  assign hiOffset = {{HI_EXT{field[OFF_W-1]}}, field, {HIGH_SHIFT{1'b0}}};
  assign loOffset = {{LO_EXT{1'b0}}, field, 1'b0};

  assign partialSum = pcValue + hiOffset;
  assign rawTarget  = lrValue + loOffset;
  assign pcBack     = pcValue - RET_BACK;
  assign retAddr    = {pcBack[ADDR_W-1:1], 1'b1};

  always_comb begin
    if (strobe.keepMode) begin
      finalTarget = {rawTarget[ADDR_W-1:1], 1'b1};
    end else begin
      finalTarget = {rawTarget[ADDR_W-1:2], 2'b00};
    end
  end

  always_comb begin
    lrNext = '0;
    if (strobe.prefixEn) begin
      lrNext = partialSum;
    end else if (strobe.suffixEn) begin
      lrNext = retAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrWrite      <= 1'b0;
      lrData       <= '0;
      branchReq    <= 1'b0;
      branchTarget <= '0;
      modeKeep     <= 1'b0;
    end else begin
      lrWrite      <= strobe.prefixEn || strobe.suffixEn;
      lrData       <= lrNext;
      branchReq    <= strobe.suffixEn;
      branchTarget <= strobe.suffixEn ? finalTarget : '0;
      modeKeep     <= strobe.keepMode;
    end
  end

  // R3
  branch_writes_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchReq |-> (lrWrite && lrData[0]));

  // R4
  keep_sets_bit0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchReq && modeKeep) |-> branchTarget[0]);

  // R5
  wide_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (branchReq && !modeKeep) |-> (branchTarget[1:0] == 2'b00));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.prefixEn && !strobe.suffixEn) |=> (!lrWrite && !branchReq && !modeKeep));

  // R1
  prefix_no_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lrWrite && !branchReq) |-> !modeKeep);

  generate
    if (ALWAYS_KEEP) begin : g_variant
      // R4
      variant_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
        branchReq |-> modeKeep);
    end
  endgenerate

endmodule

// File: rtl/long_bl_unit.sv
module long_bl_unit
  import long_bl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int HW_W        = 16,
  parameter int OFF_W       = 11,
  parameter int HIGH_SHIFT  = 12,
  parameter int MODE_POS    = 12,
  parameter bit ALWAYS_KEEP = 1'b0,
  parameter int COST_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              isSuffix,
  input  logic [HW_W-1:0]   halfword,
  input  logic [ADDR_W-1:0] pcValue,
  input  logic [ADDR_W-1:0] lrValue,
  output logic              lrWrite,
  output logic [ADDR_W-1:0] lrData,
  output logic              branchReq,
  output logic [ADDR_W-1:0] branchTarget,
  output logic              modeKeep,
  output logic [COST_W-1:0] seqCost,
  output logic [COST_W-1:0] nonseqCost
);

  blStrobe_t strobe;

  long_bl_ctrl #(
    .HW_W(HW_W), .MODE_POS(MODE_POS), .ALWAYS_KEEP(ALWAYS_KEEP), .COST_W(COST_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .isSuffix(isSuffix),
    .halfword(halfword), .strobe(strobe), .seqCost(seqCost), .nonseqCost(nonseqCost)
  );

  long_bl_datapath #(
    .ADDR_W(ADDR_W), .HW_W(HW_W), .OFF_W(OFF_W), .HIGH_SHIFT(HIGH_SHIFT),
    .ALWAYS_KEEP(ALWAYS_KEEP)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .halfword(halfword),
    .pcValue(pcValue), .lrValue(lrValue), .lrWrite(lrWrite), .lrData(lrData),
    .branchReq(branchReq), .branchTarget(branchTarget), .modeKeep(modeKeep)
  );

  // R6
  suffix_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    branchReq |-> (seqCost == COST_W'(2) && nonseqCost == COST_W'(1)));

  // R6
  prefix_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lrWrite && !branchReq) |-> (seqCost == COST_W'(1) && nonseqCost == '0));

endmodule

// File: tb/long_bl_unit_test.sv
module long_bl_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic        isSuffix = 1'b0;
  logic [15:0] halfword = '0;
  logic [31:0] pcValue = '0;
  logic [31:0] lrValue = '0;

  logic        lrWrite, branchReq, modeKeep;
  logic [31:0] lrData, branchTarget;
  logic [1:0]  seqCost, nonseqCost;
  logic        kLrWrite, kBranchReq, kModeKeep;
  logic [31:0] kLrData, kBranchTarget;
  logic [1:0]  kSeqCost, kNonseqCost;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  long_bl_unit uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .isSuffix(isSuffix),
    .halfword(halfword), .pcValue(pcValue), .lrValue(lrValue),
    .lrWrite(lrWrite), .lrData(lrData), .branchReq(branchReq),
    .branchTarget(branchTarget), .modeKeep(modeKeep),
    .seqCost(seqCost), .nonseqCost(nonseqCost)
  );

  long_bl_unit #(.ALWAYS_KEEP(1'b1)) uutKeep (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .isSuffix(isSuffix),
    .halfword(halfword), .pcValue(pcValue), .lrValue(lrValue),
    .lrWrite(kLrWrite), .lrData(kLrData), .branchReq(kBranchReq),
    .branchTarget(kBranchTarget), .modeKeep(kModeKeep),
    .seqCost(kSeqCost), .nonseqCost(kNonseqCost)
  );

  function automatic logic [31:0] modelPrefix(logic [15:0] h, logic [31:0] pc);
    return pc + {{9{h[10]}}, h[10:0], 12'b0};
  endfunction

  function automatic logic [31:0] modelRaw(logic [15:0] h, logic [31:0] lr);
    return lr + {20'b0, h[10:0], 1'b0};
  endfunction

  function automatic logic [31:0] modelTarget(logic [15:0] h, logic [31:0] lr, logic keep);
    logic [31:0] r;
    r = modelRaw(h, lr);
    return keep ? (r | 32'h1) : (r & ~32'h3);
  endfunction

  function automatic logic [31:0] modelRet(logic [31:0] pc);
    return (pc - 32'd2) | 32'h1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // Issue one halfword and check both instances one clock later.
  task automatic issue(input logic sfx, input logic [15:0] h,
                       input logic [31:0] pc, input logic [31:0] lr);
    logic [31:0] eLr, eTgt, eTgtK;
    logic        eKeep;
    issueValid = 1'b1;
    isSuffix   = sfx;
    halfword   = h;
    pcValue    = pc;
    lrValue    = lr;
    @(negedge clk);
    if (!sfx) begin
      eLr = modelPrefix(h, pc);
      chk(lrWrite && lrData == eLr, "R1 prefix link", lrData, eLr);
      chk(!branchReq && !modeKeep, "R1 prefix no branch", {30'b0, branchReq, modeKeep}, 32'h0);
      chk(kLrWrite && kLrData == eLr && !kBranchReq, "R9 prefix variant/bit12", kLrData, eLr);
      chk(seqCost == 2'd1 && nonseqCost == 2'd0, "R6 prefix cost",
          {28'b0, seqCost, nonseqCost}, 32'h4);
    end else begin
      eKeep = h[12];
      eTgt  = modelTarget(h, lr, eKeep);
      eTgtK = modelTarget(h, lr, 1'b1);
      eLr   = modelRet(pc);
      chk(branchReq, "R2 suffix branch", {31'b0, branchReq}, 32'h1);
      chk(branchTarget == eTgt, eKeep ? "R4 keep target" : "R5 wide target", branchTarget, eTgt);
      chk(modeKeep == eKeep, "R4 mode bit", {31'b0, modeKeep}, {31'b0, eKeep});
      chk(lrWrite && lrData == eLr, "R3 return link", lrData, eLr);
      chk(kBranchReq && kModeKeep && kBranchTarget == eTgtK, "R4 variant keep",
          kBranchTarget, eTgtK);
      chk(seqCost == 2'd2 && nonseqCost == 2'd1, "R6 suffix cost",
          {28'b0, seqCost, nonseqCost}, 32'h9);
    end
  endtask

  task automatic idleCheck();
    issueValid = 1'b0;
    halfword   = 16'hFFFF;
    isSuffix   = 1'b1;
    @(negedge clk);
    chk(!lrWrite && !branchReq && !modeKeep && seqCost == 0 && nonseqCost == 0,
        "R7 idle quiet", {27'b0, lrWrite, branchReq, modeKeep, |seqCost, |nonseqCost}, 32'h0);
    chk(!kLrWrite && !kBranchReq && kSeqCost == 0, "R7 idle variant",
        {30'b0, kLrWrite, kBranchReq}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%08h exp=%08h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] h;
    logic [31:0] pc, lr;
    void'($urandom(32'h5EED1234));
    issueValid = 1'b1;
    isSuffix   = 1'b1;
    halfword   = 16'h1FFF;
    pcValue    = 32'hFFFF_FFFF;
    lrValue    = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!lrWrite && lrData == 0 && !branchReq && branchTarget == 0 && !modeKeep,
        "R8 reset outputs", lrData | branchTarget, 32'h0);
    chk(seqCost == 0 && nonseqCost == 0 && !kBranchReq && !kModeKeep, "R8 reset cost",
        {28'b0, seqCost, nonseqCost}, 32'h0);
    issueValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    idleCheck();

    // R1 sign boundary of the prefix field
    issue(1'b0, 16'hF3FF, 32'h0010_0000, 32'h0);
    issue(1'b0, 16'hF400, 32'h0010_0000, 32'h0);
    issue(1'b0, 16'hF7FF, 32'h0000_0004, 32'h0);
    // R9 upper bits toggled on a prefix
    issue(1'b0, 16'h1A55, 32'h1234_5678, 32'h0);
    // R2/R4 suffix keep, then R5 odd link with bit1 set in wide mode
    issue(1'b1, 16'hF800, 32'h0000_1000, 32'h0000_2000);
    issue(1'b1, 16'hE801, 32'h0000_1000, 32'h0000_2003);
    issue(1'b1, 16'h0FFF, 32'h0000_1000, 32'hFFFF_FFFF);
    // R3 return address wraps at low program counter
    issue(1'b1, 16'hF800, 32'h0000_0000, 32'h0000_0100);
    issue(1'b1, 16'hE800, 32'h0000_0001, 32'h0000_0100);
    idleCheck();

    // prefix then suffix through the link value, mixed with random
    for (int i = 0; i < 300; i++) begin
      h  = 16'($urandom);
      pc = $urandom;
      lr = $urandom;
      if (($urandom % 5) == 0) begin
        idleCheck();
      end else begin
        issue(1'($urandom), h, pc, lr);
      end
    end
    begin
      logic [31:0] partial;
      partial = modelPrefix(16'hF7FE, 32'h0800_0004);
      issue(1'b0, 16'hF7FE, 32'h0800_0004, 32'h0);
      issue(1'b1, 16'hF802, 32'h0800_0006, partial);
    end
    idleCheck();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule